// File: doc/BRIEF.md
# Memory-to-Peripheral DMA Transmit Channel

This block is a single transmit channel of a DMA engine. Software sets a source address, a byte length and an access size, then issues a go strobe. The channel becomes a bus master on an AHB-style read interface. It fetches the source memory with single reads of the chosen width and parks each returned word in a small internal queue. A byte unpacker drains the queue and hands the bytes one at a time to a byte-wide peripheral port. That port uses a valid/acknowledge handshake and carries markers on the first and last byte.

The channel finishes in one of three ways. In a normal finish, the final byte is accepted and the channel raises its end-of-transfer interrupt. In a peripheral abort, the peripheral lowers its in-progress flag while the transfer runs. In a bus abort, the slave returns an ERROR response. Both aborts flush the queue, drop the busy state and raise the interrupt together with a cause flag.

The byte length need not be a multiple of the access width. The last read is trimmed so that exactly the programmed number of bytes reaches the peripheral.

Top module: `txdma_channel`

## Requirements
- R1: A go strobe is accepted only while the channel is not busy and its bus port is idle. An accepted strobe with a nonzero length sets `busy` one cycle later. A strobe while busy is ignored and does not change the source, the length or the byte stream.
- R2: Every memory read is a single transfer with `htrans`=2'b10 (NONSEQ) and `hwrite`=0. `hsize` takes the size field: 0 is byte, 1 is halfword, 2 is word, and 3 is treated as word. The first address is the programmed source, and each later read advances the address by 1, 2 or 4 bytes.
- R3: A read is started only when the queue has a free entry, so the queue never overflows. A transfer of L bytes at width W uses exactly ceil(L/W) reads.
- R4: While `hready` is low during an address phase, `htrans` and `haddr` hold their values.
- R5: Bytes reach the peripheral in memory order, from source to source+L-1. Each returned word is unpacked least significant lane first, starting at the lane given by the address bits [1:0]. This holds for lengths that are not a multiple of the width.
- R6: While `pr_valid` is high and `pr_ack` is low, the byte on `pr_data` is held. A byte is consumed only in a cycle where both are high.
- R7: `pr_first` is high only together with the first byte of a transfer. `pr_last` is high only together with the final byte.
- R8: The cycle after the final byte is accepted, `busy` is low, `eot_irq` is high and both error flags are low. `eot_irq` stays high until the next accepted go strobe.
- R9: A go strobe with length 0 issues no read and no byte. It raises `eot_irq` one cycle later, and `busy` stays low.
- R10: If `pr_inprog` falls while busy, then one cycle later `busy` is low, `pr_valid` is low, and `err_abort` and `eot_irq` are high. The queue is flushed, so the next transfer delivers only its own bytes.
- R11: An ERROR response on a read ends the transfer. `busy` goes low and `err_bus` and `eot_irq` go high.
- R12: After reset, `busy`, `eot_irq`, both error flags, `pr_valid` and `htrans` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src | input | ADDR_W | Source start address |
| cfg_len | input | CNT_W | Transfer length in bytes |
| cfg_size | input | 2 | Access size (0 byte, 1 half, 2/3 word) |
| cfg_go | input | 1 | Enable strobe, written last |
| busy | output | 1 | Transfer in progress |
| eot_irq | output | 1 | End-of-transfer interrupt (level) |
| err_abort | output | 1 | Ended by peripheral dropping in-progress |
| err_bus | output | 1 | Ended by bus ERROR response |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Bus transfer type |
| hsize | output | 3 | Bus access size |
| hwrite | output | 1 | Bus write (always 0) |
| hrdata | input | 32 | Bus read data |
| hready | input | 1 | Bus ready |
| hresp | input | 1 | Bus response, 1 = ERROR |
| pr_data | output | 8 | Byte to the peripheral |
| pr_valid | output | 1 | Byte valid |
| pr_first | output | 1 | First-byte marker |
| pr_last | output | 1 | Last-byte marker |
| pr_ack | input | 1 | Byte accepted by the peripheral |
| pr_inprog | input | 1 | Peripheral in-progress flag |

## Verification
The hardest state to reach from the ports is a queue that stays full while the bus side keeps trying to fetch. Only then does the free-entry gate on new reads actually decide anything. The stimulus acknowledges one byte in eight cycles on a long word transfer. The bench then bounds the number of accepted reads by the bytes drained plus the queue depth. A second hard case is an abort that arrives with bytes still queued and a read possibly in flight. The peripheral drops its flag part way through a long transfer, and an immediate follow-up transfer must deliver only its own bytes.

// File: rtl/txdma_pkg.sv
`timescale 1ns/1ps
package txdma_pkg;

    localparam logic [1:0] HT_IDLE   = 2'b00;
    localparam logic [1:0] HT_NONSEQ = 2'b10;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_ADDR = 2'd1,
        BUS_DATA = 2'd2
    } bus_st_e;

    // One queue entry: a returned bus word, the lane of its first valid
    // byte and how many bytes of it belong to the transfer.
    typedef struct packed {
        logic [31:0] data;
        logic [1:0]  lane;
        logic [2:0]  nbytes;
    } q_ent_t;

    function automatic logic [1:0] eff_size(input logic [1:0] s);
        return (s == 2'd3) ? 2'd2 : s;
    endfunction

    function automatic logic [2:0] size_bytes(input logic [1:0] s);
        case (s)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/txdma_rd_seq.sv
`timescale 1ns/1ps
module txdma_rd_seq
    import txdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] src,
    input  logic [CNT_W-1:0]  len,
    input  logic [1:0]        size,
    input  logic              active,
    input  logic              room,
    output logic              bus_idle,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic [2:0]        hsize,
    output logic              hwrite,
    input  logic [31:0]       hrdata,
    input  logic              hready,
    input  logic              hresp,
    output logic              push,
    output q_ent_t            push_ent,
    output logic              bus_err
);

    bus_st_e           st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [1:0]        sz_q;
    logic [2:0]        sb;
    logic [2:0]        nb;
    logic              dphase_end;

    assign sb         = size_bytes(sz_q);
    assign nb         = (left_q < CNT_W'(sb)) ? left_q[2:0] : sb;
    assign dphase_end = (st_q == BUS_DATA) && hready;
    assign push       = dphase_end && !hresp && active;
    assign bus_err    = dphase_end && hresp && active;
    assign push_ent   = '{data: hrdata, lane: addr_q[1:0], nbytes: nb};

    assign bus_idle = (st_q == BUS_IDLE);
    assign htrans   = (st_q == BUS_ADDR) ? HT_NONSEQ : HT_IDLE;
    assign haddr    = addr_q;
    assign hsize    = {1'b0, sz_q};
    assign hwrite   = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= BUS_IDLE;
            addr_q <= '0;
            left_q <= '0;
            sz_q   <= 2'd0;
        end else begin
            if (load) begin
                addr_q <= src;
                left_q <= len;
                sz_q   <= eff_size(size);
            end
            case (st_q)
                BUS_IDLE: if (active && !load && left_q != '0 && room) st_q <= BUS_ADDR;
                BUS_ADDR: if (hready) st_q <= BUS_DATA;
                BUS_DATA: if (hready) begin
                    st_q <= BUS_IDLE;
                    if (push) begin
                        addr_q <= addr_q + ADDR_W'(sb);
                        left_q <= left_q - CNT_W'(nb);
                    end
                end
                default: st_q <= BUS_IDLE;
            endcase
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q == BUS_ADDR && !hready) |=> (htrans == HT_NONSEQ && $stable(haddr))); // R4
    AST_ISSUE_ROOM: assert property (@(posedge clk) disable iff (rst)
        $rose(htrans[1]) |-> $past(room)); // R3
    AST_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        htrans[1] |-> !hwrite); // R2

endmodule

// File: rtl/txdma_queue.sv
`timescale 1ns/1ps
module txdma_queue
    import txdma_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  logic   push,
    input  q_ent_t din,
    input  logic   pop,
    output q_ent_t dout,
    output logic   empty,
    output logic   room
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    q_ent_t          mem [DEPTH];
    logic [AW-1:0]   wr_q, rd_q;
    logic [CW-1:0]   cnt_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty = (cnt_q == '0);
    assign room  = (cnt_q != CW'(DEPTH));
    assign dout  = mem[rd_q];

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= nxt(wr_q);
            if (pop)  rd_q <= nxt(rd_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && !flush) |-> room); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (pop && !flush) |-> !empty); // R5

endmodule

// File: rtl/txdma_unpack.sv
`timescale 1ns/1ps
module txdma_unpack
    import txdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             active,
    input  q_ent_t           head,
    input  logic             empty,
    output logic             pop,
    output logic             last_taken,
    output logic [7:0]       pr_data,
    output logic             pr_valid,
    output logic             pr_first,
    output logic             pr_last,
    input  logic             pr_ack
);

    logic [1:0]       idx_q;
    logic [CNT_W-1:0] left_q;
    logic             first_q;
    logic [1:0]       lane;
    logic             take;

    assign lane       = head.lane + idx_q;
    assign pr_valid   = active && !empty;
    assign pr_data    = head.data[{lane, 3'b000} +: 8];
    assign pr_first   = pr_valid && first_q;
    assign pr_last    = pr_valid && (left_q == CNT_W'(1));
    assign take       = pr_valid && pr_ack;
    assign pop        = take && (({1'b0, idx_q} + 3'd1) == head.nbytes);
    assign last_taken = take && (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= 2'd0;
            left_q  <= '0;
            first_q <= 1'b0;
        end else if (load) begin
            idx_q   <= 2'd0;
            left_q  <= len;
            first_q <= 1'b1;
        end else if (take) begin
            idx_q   <= pop ? 2'd0 : idx_q + 2'd1;
            left_q  <= left_q - CNT_W'(1);
            first_q <= 1'b0;
        end
    end

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (rst)
        (pr_valid && !pr_ack) |=> (!active || (pr_valid && $stable(pr_data)))); // R6
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        (pr_last || pr_first) |-> pr_valid); // R7

endmodule

// File: rtl/txdma_channel.sv
`timescale 1ns/1ps
module txdma_channel
    import txdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [CNT_W-1:0]  cfg_len,
    input  logic [1:0]        cfg_size,
    input  logic              cfg_go,
    output logic              busy,
    output logic              eot_irq,
    output logic              err_abort,
    output logic              err_bus,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic [2:0]        hsize,
    output logic              hwrite,
    input  logic [31:0]       hrdata,
    input  logic              hready,
    input  logic              hresp,
    output logic [7:0]        pr_data,
    output logic              pr_valid,
    output logic              pr_first,
    output logic              pr_last,
    input  logic              pr_ack,
    input  logic              pr_inprog
);

    logic   active_q, inprog_q, irq_q, eabort_q, ebus_q;
    logic   accept, drop, flush;
    logic   bus_idle, room, empty, push, pop, bus_err, last_taken;
    q_ent_t push_ent, head;

    assign accept = cfg_go && !active_q && bus_idle;
    assign drop   = active_q && inprog_q && !pr_inprog;
    assign flush  = accept || drop || bus_err;

    assign busy      = active_q;
    assign eot_irq   = irq_q;
    assign err_abort = eabort_q;
    assign err_bus   = ebus_q;

    txdma_rd_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_rd (
        .clk(clk), .rst(rst), .load(accept), .src(cfg_src), .len(cfg_len),
        .size(cfg_size), .active(active_q), .room(room), .bus_idle(bus_idle),
        .haddr(haddr), .htrans(htrans), .hsize(hsize), .hwrite(hwrite),
        .hrdata(hrdata), .hready(hready), .hresp(hresp),
        .push(push), .push_ent(push_ent), .bus_err(bus_err)
    );

    txdma_queue #(.DEPTH(FIFO_DEPTH)) i_q (
        .clk(clk), .rst(rst), .flush(flush), .push(push), .din(push_ent),
        .pop(pop && !flush), .dout(head), .empty(empty), .room(room)
    );

    txdma_unpack #(.CNT_W(CNT_W)) i_up (
        .clk(clk), .rst(rst), .load(accept), .len(cfg_len), .active(active_q),
        .head(head), .empty(empty), .pop(pop), .last_taken(last_taken),
        .pr_data(pr_data), .pr_valid(pr_valid), .pr_first(pr_first),
        .pr_last(pr_last), .pr_ack(pr_ack)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            inprog_q <= 1'b0;
            irq_q    <= 1'b0;
            eabort_q <= 1'b0;
            ebus_q   <= 1'b0;
        end else begin
            inprog_q <= pr_inprog;
            if (accept) begin
                active_q <= (cfg_len != '0);
                irq_q    <= (cfg_len == '0);
                eabort_q <= 1'b0;
                ebus_q   <= 1'b0;
            end else if (drop) begin
                active_q <= 1'b0;
                irq_q    <= 1'b1;
                eabort_q <= 1'b1;
            end else if (bus_err) begin
                active_q <= 1'b0;
                irq_q    <= 1'b1;
                ebus_q   <= 1'b1;
            end else if (last_taken) begin
                active_q <= 1'b0;
                irq_q    <= 1'b1;
            end
        end
    end

    AST_IRQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(eot_irq) |-> !busy); // R8
    AST_ABORT_STOP: assert property (@(posedge clk) disable iff (rst)
        drop |=> (!pr_valid && err_abort && eot_irq && !busy)); // R10
    AST_BUSERR_STOP: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> (err_bus && eot_irq && !busy)); // R11
    AST_BUSY_IGNORES_GO: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_go && !drop && !bus_err && !last_taken) |=> busy); // R1

endmodule

// File: tb/test_txdma_channel.sv
`timescale 1ns/1ps
module test_txdma_channel;

    localparam int DEPTH = 4;

    typedef struct packed {
        logic [31:0] src;
        logic [15:0] len;
        logic [1:0]  sz;
        logic [7:0]  wmask;
        logic [7:0]  amask;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0100, 16'd8,  2'd2, 8'hFF, 8'hFF},
        '{32'h0000_0203, 16'd7,  2'd0, 8'hB6, 8'h6D},
        '{32'h0000_0402, 16'd9,  2'd1, 8'hDB, 8'hFF},
        '{32'h0000_0610, 16'd13, 2'd2, 8'h7E, 8'h35},
        '{32'h0000_0800, 16'd1,  2'd2, 8'hFF, 8'hFF},
        '{32'h0000_09F0, 16'd20, 2'd2, 8'hFF, 8'h01},
        '{32'h0000_0A00, 16'd6,  2'd3, 8'hEF, 8'hF7}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_src = '0;
    logic [15:0] cfg_len = '0;
    logic [1:0]  cfg_size = '0;
    logic        cfg_go = 1'b0;
    logic        busy, eot_irq, err_abort, err_bus;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic [2:0]  hsize;
    logic        hwrite;
    logic [31:0] hrdata = '0;
    logic        hready = 1'b1;
    logic        hresp = 1'b0;
    logic [7:0]  pr_data;
    logic        pr_valid, pr_first, pr_last;
    logic        pr_ack = 1'b0;
    logic        pr_inprog = 1'b1;

    txdma_channel #(.ADDR_W(32), .CNT_W(16), .FIFO_DEPTH(DEPTH)) i_txdma_channel (
        .clk(clk), .rst(rst), .cfg_src(cfg_src), .cfg_len(cfg_len),
        .cfg_size(cfg_size), .cfg_go(cfg_go), .busy(busy), .eot_irq(eot_irq),
        .err_abort(err_abort), .err_bus(err_bus), .haddr(haddr), .htrans(htrans),
        .hsize(hsize), .hwrite(hwrite), .hrdata(hrdata), .hready(hready),
        .hresp(hresp), .pr_data(pr_data), .pr_valid(pr_valid),
        .pr_first(pr_first), .pr_last(pr_last), .pr_ack(pr_ack),
        .pr_inprog(pr_inprog)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mb(input logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] mword(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return {mb(w + 32'd3), mb(w + 32'd2), mb(w + 32'd1), mb(w)};
    endfunction

    // transfer context used by the bus and peripheral models
    logic [31:0] cur_src = '0;
    int          cur_len = 0;
    int          cur_sb = 4;
    logic [2:0]  cur_hsize = 3'd2;
    logic [7:0]  wmask = 8'hFF;
    logic [7:0]  amask = 8'hFF;
    int          bytes_got = 0;
    int          reads = 0;
    int          err_at = 0;
    int          drop_at = -1;
    bit          flow_bad = 1'b0;
    int          cyc = 0;

    bit          dp_active = 1'b0;
    logic [31:0] dp_addr = '0;
    bit          nseq_prev = 1'b0;
    logic [31:0] addr_prev = '0;
    logic [2:0]  hsize_prev = '0;
    bit          err_phase = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            hready = 1'b1; hresp = 1'b0; pr_ack = 1'b0; pr_inprog = 1'b1;
            dp_active = 1'b0; nseq_prev = 1'b0; err_phase = 1'b0;
        end else begin
            cyc++;
            // bus slave model
            if (dp_active && hready) dp_active = 1'b0;
            if (nseq_prev && hready) begin
                check(addr_prev == cur_src + 32'(reads * cur_sb), "R2 read address",
                      addr_prev, cur_src + 32'(reads * cur_sb));
                check(hsize_prev == cur_hsize, "R2 read size", 32'(hsize_prev), 32'(cur_hsize));
                dp_active = 1'b1;
                dp_addr   = addr_prev;
                reads++;
            end else if (nseq_prev && !hready) begin
                check(htrans == 2'b10 && haddr == addr_prev, "R4 address hold", haddr, addr_prev);
            end
            if (dp_active && err_at != 0 && reads == err_at) begin
                hresp = 1'b1;
                if (!err_phase) begin
                    hready = 1'b0; err_phase = 1'b1;
                end else begin
                    hready = 1'b1; err_phase = 1'b0; err_at = 0;
                end
            end else begin
                hresp  = 1'b0;
                hready = wmask[cyc % 8];
            end
            hrdata     = mword(dp_addr);
            nseq_prev  = (htrans == 2'b10);
            addr_prev  = haddr;
            hsize_prev = hsize;
            // peripheral model
            if (drop_at >= 0 && bytes_got == drop_at) begin
                pr_inprog = 1'b0;
                pr_ack    = 1'b0;
            end else begin
                pr_inprog = 1'b1;
                pr_ack    = amask[cyc % 8];
                if (pr_valid) begin
                    check(pr_data == mb(cur_src + 32'(bytes_got)),
                          pr_ack ? "R5 byte order" : "R6 held byte",
                          32'(pr_data), 32'(mb(cur_src + 32'(bytes_got))));
                    if (pr_ack) begin
                        check(pr_first == (bytes_got == 0), "R7 first marker",
                              32'(pr_first), 32'(bytes_got == 0));
                        check(pr_last == (bytes_got == cur_len - 1), "R7 last marker",
                              32'(pr_last), 32'(bytes_got == cur_len - 1));
                        bytes_got++;
                    end
                end
            end
            if (cur_sb == 4 && reads > bytes_got / 4 + DEPTH + 1) flow_bad = 1'b1;
        end
    end

    task automatic start_xfer(input logic [31:0] src, input int len, input logic [1:0] sz);
        bytes_got = 0; reads = 0; flow_bad = 1'b0;
        cur_src = src; cur_len = len;
        cur_sb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        cur_hsize = (sz == 2'd3) ? 3'd2 : {1'b0, sz};
        @(negedge clk);
        cfg_src = src; cfg_len = 16'(len); cfg_size = sz; cfg_go = 1'b1;
        @(negedge clk);
        cfg_go = 1'b0;
    endtask

    task automatic wait_irq(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            #1;
            if (eot_irq) begin
                seen = 1'b1;
                return;
            end
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        bit seen;
        int exp_reads;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R12 reset state
        check({busy, eot_irq, err_abort, err_bus, pr_valid} == 5'b0, "R12 reset outputs",
              32'({busy, eot_irq, err_abort, err_bus, pr_valid}), 32'h0);
        check(htrans == 2'b00, "R12 reset htrans", 32'(htrans), 32'h0);

        // table of normal transfers
        for (int v = 0; v < NV; v++) begin
            wmask = VECS[v].wmask;
            amask = VECS[v].amask;
            start_xfer(VECS[v].src, int'(VECS[v].len), VECS[v].sz);
            #1;
            check(busy == 1'b1, "R1 busy after go", 32'(busy), 32'h1);
            wait_irq(seen);
            check(seen, "R8 interrupt raised", 32'(seen), 32'h1);
            exp_reads = (cur_len + cur_sb - 1) / cur_sb;
            check(bytes_got == cur_len, "R5 byte count", 32'(bytes_got), 32'(cur_len));
            check(reads == exp_reads, "R3 read count", 32'(reads), 32'(exp_reads));
            check({busy, err_abort, err_bus} == 3'b0, "R8 idle and clean",
                  32'({busy, err_abort, err_bus}), 32'h0);
            check(!flow_bad, "R3 queue gates reads", 32'(flow_bad), 32'h0);
            repeat (3) @(negedge clk); #1;
            check(eot_irq == 1'b1, "R8 interrupt held", 32'(eot_irq), 32'h1);
        end
        wmask = 8'hFF; amask = 8'hFF;

        // R9 zero length
        start_xfer(32'h0000_0C00, 0, 2'd2);
        #1;
        check(eot_irq == 1'b1 && busy == 1'b0, "R9 zero length completes",
              32'({eot_irq, busy}), 32'h2);
        repeat (10) @(negedge clk); #1;
        check(reads == 0 && bytes_got == 0, "R9 no reads or bytes", 32'(reads + bytes_got), 32'h0);

        // R1 go while busy is ignored
        amask = 8'h11;
        start_xfer(32'h0000_0D00, 12, 2'd2);
        repeat (6) @(negedge clk);
        cfg_src = 32'h0000_0E40; cfg_len = 16'd3; cfg_size = 2'd0; cfg_go = 1'b1;
        @(negedge clk);
        cfg_go = 1'b0;
        wait_irq(seen);
        check(bytes_got == 12, "R1 go while busy ignored", 32'(bytes_got), 32'd12);
        check(reads == 3, "R1 read count unchanged", 32'(reads), 32'd3);
        amask = 8'hFF;

        // R10 peripheral drops in-progress mid transfer
        amask = 8'h55;
        drop_at = 5;
        start_xfer(32'h0000_1000, 40, 2'd2);
        wait_irq(seen);
        check(seen, "R10 abort raises interrupt", 32'(seen), 32'h1);
        check(err_abort == 1'b1 && err_bus == 1'b0, "R10 abort flag",
              32'({err_abort, err_bus}), 32'h2);
        check(busy == 1'b0 && pr_valid == 1'b0, "R10 stopped", 32'({busy, pr_valid}), 32'h0);
        check(bytes_got == 5, "R10 no bytes after drop", 32'(bytes_got), 32'd5);
        drop_at = -1;
        repeat (4) @(negedge clk);
        // follow-up transfer must not see stale queue entries
        start_xfer(32'h0000_1200, 10, 2'd2);
        wait_irq(seen);
        check(bytes_got == 10 && err_abort == 1'b0, "R10 flushed before next transfer",
              32'(bytes_got), 32'd10);
        amask = 8'hFF;

        // R11 bus ERROR on the second read
        err_at = 2;
        amask = 8'h03;
        start_xfer(32'h0000_1400, 16, 2'd2);
        wait_irq(seen);
        check(seen && err_bus == 1'b1 && err_abort == 1'b0, "R11 bus error flag",
              32'({seen, err_bus, err_abort}), 32'h6);
        check(busy == 1'b0, "R11 busy cleared", 32'(busy), 32'h0);
        repeat (4) @(negedge clk); #1;
        check(pr_valid == 1'b0 && reads == 2, "R11 no further activity",
              32'(reads), 32'd2);
        err_at = 0;
        amask = 8'hFF;

        // R12 reset mid transfer returns to idle
        start_xfer(32'h0000_1600, 30, 2'd0);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check({busy, eot_irq, pr_valid} == 3'b0 && htrans == 2'b00, "R12 reset during transfer",
              32'({busy, eot_irq, pr_valid}), 32'h0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule